// File: doc/BRIEF.md
# Auto-Triggered Hit Frame Memory

This block sits behind the discriminators of a 64-channel digital calorimeter readout chip. Every channel reports a 2-bit hit code. Whenever the combined trigger signal or an external force input is asserted during acquisition, the block stores one frame. A frame is a snapshot of all channel codes, the running bunch-crossing count and a fixed header byte.

Frames go into a 128-entry frame memory. A readout controller drains the memory in arrival order through a show-ahead read port. The controller can see how many frames are held. A full flag tells the surrounding logic that further triggers will be dropped.

The bunch-crossing counter runs only while acquisition is enabled. Every stored frame therefore carries the count of the crossing in which its trigger was seen.

Top module: `hit_frame_mem`

## Requirements
- R1: After rst_ni is released, frame_cnt_o is 0, rd_valid_o is 0, full_o is 0 and the bunch-crossing counter is 0.
- R2: In a clock cycle with acq_en_i=1, trig_or_i=1 and full_o=0, exactly one frame is written, and it holds the hit codes present in that cycle.
- R3: force_trig_i=1 writes a frame under the same conditions as R2 even when trig_or_i=0.
- R4: The frame layout is: bits [159:152] hold the header parameter HDR_VAL (default 8'hA5), bits [151:128] hold the 24-bit bunch-crossing count, and bits [2k+1:2k] hold the code of channel k.
- R5: The bunch-crossing counter starts at 0 and increments by one on every clock edge while acq_en_i=1. It holds its value while acq_en_i=0. The stored count is the counter value during the trigger cycle.
- R6: At most one frame is written per clock. A trigger held high for N cycles writes N frames, one per cycle.
- R7: full_o is 1 exactly when 128 frames are held. While full, triggers are dropped, even in a cycle that also reads, and no stored frame is altered.
- R8: rd_valid_o is 1 whenever at least one frame is held, and rd_frame_o shows the oldest frame. rd_req_i=1 with rd_valid_o=1 removes that frame on the clock edge. Frames leave in write order.
- R9: frame_cnt_o gives the number of frames held. It stays unchanged in a cycle that both writes and reads.
- R10: While acq_en_i=0, trig_or_i and force_trig_i have no effect: no frame is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acq_en_i | input | 1 | Acquisition enable; gates triggers and the crossing counter |
| hit_code_i | input | 128 | 2-bit code per channel, channel k at [2k+1:2k] |
| trig_or_i | input | 1 | OR of all channel threshold crossings |
| force_trig_i | input | 1 | External forced trigger |
| rd_req_i | input | 1 | Pop the oldest frame |
| rd_valid_o | output | 1 | At least one frame held |
| rd_frame_o | output | 160 | Oldest frame (show-ahead) |
| frame_cnt_o | output | 8 | Number of frames held |
| full_o | output | 1 | Memory holds 128 frames |

## Verification
On every cycle, the assertions check the following:
- the occupancy never exceeds the depth and never moves by more than one step;
- a full memory rejects writes;
- disabled acquisition freezes both the occupancy and the crossing counter;
- a qualified trigger or a pop moves the count in the expected direction.

Some properties need the bench's scenarios, which compare full frame contents against a model queue. These are the frame layout, the crossing value captured in each frame, the arrival order across a complete fill and drain, and the fact that frames stored before the full condition survive the triggers dropped at full.

// File: rtl/hfm_pkg.sv
package hfm_pkg;
  localparam int unsigned N_CH_D   = 64;
  localparam int unsigned CODE_W_D = 2;
  localparam int unsigned BCID_W_D = 24;
  localparam int unsigned HDR_W_D  = 8;
  localparam int unsigned DEPTH_D  = 128;
  localparam logic [HDR_W_D-1:0] HDR_VAL_D = 8'hA5;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_WRRD = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/hfm_bcid_counter.sv
module hfm_bcid_counter #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (en_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/hfm_frame_ctrl.sv
module hfm_frame_ctrl
  import hfm_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          rd_en;
  fifo_op_e      op;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  // full check uses current occupancy: a same-cycle pop does not admit a write
  assign wr_en_o = wr_req_i & ~full_o;
  assign rd_en   = rd_req_i & ~empty_o;
  assign op      = fifo_op_e'({rd_en, wr_en_o});

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_en_o) wr_ptr_q <= inc_ptr(wr_ptr_q);
      if (rd_en)   rd_ptr_q <= inc_ptr(rd_ptr_q);
      unique case (op)
        OP_WR:   cnt_q <= cnt_q + CW'(1);
        OP_RD:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_addr_o = wr_ptr_q;
  assign rd_addr_o = rd_ptr_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/hfm_frame_ram.sv
module hfm_frame_ram #(
  parameter int unsigned W     = 160,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/hit_frame_mem.sv
module hit_frame_mem
  import hfm_pkg::*;
#(
  parameter int unsigned N_CH    = N_CH_D,
  parameter int unsigned CODE_W  = CODE_W_D,
  parameter int unsigned BCID_W  = BCID_W_D,
  parameter int unsigned HDR_W   = HDR_W_D,
  parameter int unsigned DEPTH   = DEPTH_D,
  parameter logic [HDR_W-1:0] HDR_VAL = HDR_VAL_D,
  localparam int unsigned HIT_W   = N_CH * CODE_W,
  localparam int unsigned FRAME_W = HDR_W + BCID_W + HIT_W,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acq_en_i,
  input  logic [HIT_W-1:0]   hit_code_i,
  input  logic               trig_or_i,
  input  logic               force_trig_i,
  input  logic               rd_req_i,
  output logic               rd_valid_o,
  output logic [FRAME_W-1:0] rd_frame_o,
  output logic [CW-1:0]      frame_cnt_o,
  output logic               full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BCID_W-1:0]  bcid_q;
  logic               trig_req;
  logic               wr_en;
  logic               empty;
  logic [AW-1:0]      wr_addr, rd_addr;
  logic [FRAME_W-1:0] frame_d;

  assign trig_req = acq_en_i & (trig_or_i | force_trig_i);
  assign frame_d  = {HDR_VAL, bcid_q, hit_code_i};

  hfm_bcid_counter #(.W(BCID_W)) u_bcid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (acq_en_i),
    .cnt_o  (bcid_q)
  );

  hfm_frame_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (trig_req),
    .rd_req_i  (rd_req_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_addr_o (rd_addr),
    .cnt_o     (frame_cnt_o),
    .full_o    (full_o),
    .empty_o   (empty)
  );

  hfm_frame_ram #(.W(FRAME_W), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (frame_d),
    .raddr_i (rd_addr),
    .rdata_o (rd_frame_o)
  );

  assign rd_valid_o = ~empty;
endmodule

// File: rtl/hfm_checker.sv
module hfm_checker #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned CW     = 8,
  parameter int unsigned BCID_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acq_en_i,
  input logic              trig_or_i,
  input logic              force_trig_i,
  input logic              rd_req_i,
  input logic              rd_valid_o,
  input logic              full_o,
  input logic [CW-1:0]     frame_cnt_o,
  input logic [BCID_W-1:0] bcid
);
  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_cnt_o <= CW'(DEPTH));

  p_one_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (frame_cnt_o == $past(frame_cnt_o)) ||
             (frame_cnt_o == $past(frame_cnt_o) + CW'(1)) ||
             (frame_cnt_o == $past(frame_cnt_o) - CW'(1)));

  p_full_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !rd_req_i |=> full_o && (frame_cnt_o == $past(frame_cnt_o)));

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_en_i && (trig_or_i || force_trig_i) && !full_o && !rd_req_i
    |=> frame_cnt_o == $past(frame_cnt_o) + CW'(1));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acq_en_i && !rd_req_i |=> $stable(frame_cnt_o));

  p_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && rd_valid_o && !(acq_en_i && (trig_or_i || force_trig_i))
    |=> frame_cnt_o == $past(frame_cnt_o) - CW'(1));

  p_bcid_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_en_i |=> bcid == $past(bcid) + BCID_W'(1));

  p_bcid_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acq_en_i |=> $stable(bcid));
endmodule

bind hit_frame_mem hfm_checker #(.DEPTH(DEPTH), .CW(CW), .BCID_W(BCID_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acq_en_i     (acq_en_i),
  .trig_or_i    (trig_or_i),
  .force_trig_i (force_trig_i),
  .rd_req_i     (rd_req_i),
  .rd_valid_o   (rd_valid_o),
  .full_o       (full_o),
  .frame_cnt_o  (frame_cnt_o),
  .bcid         (bcid_q)
);

// File: tb/tb_hit_frame_mem.sv
module tb_hit_frame_mem;
  localparam int DEPTH = 128;
  localparam int HIT_W = 128;
  localparam int FW    = 160;
  localparam logic [7:0] HDR = 8'hA5;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            acq_en_i = 1'b0;
  logic [HIT_W-1:0] hit_code_i = '0;
  logic            trig_or_i = 1'b0;
  logic            force_trig_i = 1'b0;
  logic            rd_req_i = 1'b0;
  logic            rd_valid_o;
  logic [FW-1:0]   rd_frame_o;
  logic [7:0]      frame_cnt_o;
  logic            full_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [FW-1:0] q [$];
  logic [23:0]   bcid_m = '0;

  always #4 clk_i = ~clk_i;

  hit_frame_mem dut (
    .clk_i, .rst_ni, .acq_en_i, .hit_code_i, .trig_or_i, .force_trig_i,
    .rd_req_i, .rd_valid_o, .rd_frame_o, .frame_cnt_o, .full_o
  );

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act,
                     input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [HIT_W-1:0] mk_codes(input int seed);
    logic [HIT_W-1:0] v;
    for (int k = 0; k < 64; k++) v[2*k +: 2] = 2'((k * 3 + seed + (seed >> 2)) & 3);
    return v;
  endfunction

  // one clock: inputs set at negedge, model updated, results sampled next negedge
  task automatic cyc(input bit acq, input bit trg, input bit frc, input bit rd,
                     input logic [HIT_W-1:0] codes, input string req);
    int sz;
    acq_en_i = acq; trig_or_i = trg; force_trig_i = frc; rd_req_i = rd;
    hit_code_i = codes;
    sz = q.size();
    if (rd && sz > 0) begin
      chk(rd_frame_o === q[0], "R8 frame order", rd_frame_o, q[0]);
      void'(q.pop_front());
    end
    if (acq && (trg || frc) && sz < DEPTH) q.push_back({HDR, bcid_m, codes});
    if (acq) bcid_m++;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(frame_cnt_o == 8'(q.size()), req, FW'(frame_cnt_o), FW'(q.size()));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(frame_cnt_o == 0, "R1 count", FW'(frame_cnt_o), 0);
    chk(!rd_valid_o && !full_o, "R1 flags", FW'({rd_valid_o, full_o}), 0);

    // R5 counter runs idle, R2/R4 first frame captures codes and count
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, '0, "R5 idle");
    cyc(1, 1, 0, 0, mk_codes(1), "R2 write");
    chk(rd_valid_o, "R8 valid", FW'(rd_valid_o), 1);
    chk(rd_frame_o === {HDR, 24'd5, mk_codes(1)}, "R4 layout", rd_frame_o,
        {HDR, 24'd5, mk_codes(1)});

    // R3 force trigger alone
    cyc(1, 0, 1, 0, mk_codes(2), "R3 force");

    // R10 triggers with acquisition off; R5 counter holds
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, mk_codes(9), "R10 ignored");
    cyc(1, 1, 0, 0, mk_codes(3), "R5 held count");

    // R6 trigger held over 4 cycles
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, mk_codes(10 + i), "R6 held trigger");

    // R9 simultaneous write and read
    cyc(1, 1, 0, 1, mk_codes(20), "R9 wr+rd");

    // R8 drain
    while (q.size() > 0) cyc(0, 0, 0, 1, '0, "R8 drain");
    chk(!rd_valid_o, "R8 empty", FW'(rd_valid_o), 0);

    // R7 fill to depth
    for (int i = 0; i < DEPTH; i++) cyc(1, i % 2, (i + 1) % 2, 0, mk_codes(100 + i), "R7 fill");
    chk(full_o, "R7 full", FW'(full_o), 1);
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, mk_codes(7), "R7 dropped");
    cyc(1, 1, 0, 1, mk_codes(8), "R7 full read drops write");
    chk(!full_o, "R7 not full", FW'(full_o), 0);
    while (q.size() > 0) cyc(1, 0, 0, 1, '0, "R8 drain full");
    chk(frame_cnt_o == 0 && !rd_valid_o, "R8 empty end", FW'(frame_cnt_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule